// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block is a synchronous reset controller. It watches a digital flag from a supply comparator that is high while the supply sits below the brown-out threshold. A 2-bit mode field decides whether that flag is used at all: never, always, under a software enable, or only while the device is awake. A dip has to last longer than a set number of clock cycles before it counts. A counter drops shorter pulses so that noise on the comparator does not reset the chip.

After any reset source (power-on, watchdog or a qualified brown-out), the single reset output stays high while the supply is low. When the supply recovers, the reset either releases at once or is stretched by a power-up timer that is enabled by an active-low bit. A new dip while the timer runs sends the sequencer back to the brown-out state. The timer then starts again from zero once the supply recovers. A sticky status bit records each brown-out reset until software clears it. All intervals are clock-cycle counts set by parameters.

Top module: `bor_reset_seq`

## Requirements
- R1: While `por_i` is high, `rst_o` is high from the next clock edge and `bor_flag_o` is 0.
- R2: Mode `mode_i`=2'b00 ignores the supply flag entirely. Mode 2'b11 uses it regardless of `sw_en_i` and `sleep_i`.
- R3: In mode 2'b01 the supply flag is used only while `sw_en_i` is 1.
- R4: In mode 2'b10 the supply flag is used only while `sleep_i` is 0, and `sw_en_i` has no effect.
- R5: While in normal run, a supply flag that stays high for FILT_CYC consecutive synchronised cycles or fewer causes no reset. One that stays high for FILT_CYC+1 or more causes a reset.
- R6: After a reset source, `rst_o` stays high for as long as the enabled supply flag stays high.
- R7: With `pwrt_en_n_i`=0, `rst_o` falls on the (PWRT_CYC+3)th rising edge after the supply flag falls (or after `por_i` is released with the supply good). With `pwrt_en_n_i`=1 it falls on the 3rd such edge.
- R8: A supply dip while the power-up timer runs returns the block to the brown-out state. After recovery the full PWRT_CYC interval runs again from zero.
- R9: A one-cycle `wdt_req_i` pulse during run raises `rst_o` on the next edge and then runs the normal release sequence (PWRT_CYC+1 cycles high with the timer enabled). The pulse does not set `bor_flag_o`.
- R10: `bor_flag_o` is set when the block enters the brown-out state and is cleared by `flag_clr_i`. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset request, active high, synchronous |
| wdt_req_i | input | 1 | Watchdog reset request pulse |
| brown_raw_i | input | 1 | Asynchronous comparator flag, high when supply is below threshold |
| mode_i | input | 2 | Detector mode: 00 off, 01 software-gated, 10 off in sleep, 11 always on |
| sw_en_i | input | 1 | Software detector enable, used in mode 01 only |
| sleep_i | input | 1 | High while the device sleeps |
| pwrt_en_n_i | input | 1 | Power-up timer enable, active low |
| flag_clr_i | input | 1 | Clears the brown-out status flag |
| rst_o | output | 1 | Internal reset, active high, registered |
| bor_flag_o | output | 1 | Sticky brown-out status |

## Verification
Entry into the brown-out state sets the status flag, and a software clear can arrive in the very same cycle. The bench holds `flag_clr_i` high from the moment the supply flag rises. It drops the clear right after the edge on which the filter qualifies the dip, which comes FILT_CYC+3 edges after the rise. The bench then requires the flag to read 1. A separate clear with no brown-out pending must read 0 on the next cycle.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BOR  = 2'd1,
    ST_PWRT = 2'd2,
    ST_RUN  = 2'd3
  } bor_state_t;

  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_SW    = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;
  localparam logic [1:0] MODE_ON    = 2'b11;

  function automatic logic det_enable(input logic [1:0] mode,
                                      input logic       sw_en,
                                      input logic       sleep);
    case (mode)
      MODE_SW:    return sw_en;
      MODE_SLEEP: return ~sleep;
      MODE_ON:    return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bor_glitch_filter.sv
module bor_glitch_filter #(
  parameter int FILT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q;
  logic          active;

  assign active = en & flag;

  always_ff @(posedge clk) begin
    if (rst || !active)       cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
  end

  assign trip = active && (cnt_q == CNT_MAX);
endmodule

// File: rtl/bor_seq_fsm.sv
module bor_seq_fsm
  import bor_pkg::*;
#(
  parameter int PWRT_CYC = 65536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       low,
  input  logic       trip,
  input  logic       wdt,
  input  logic       pwrt_on,
  output bor_state_t state_o,
  output logic       rst_o,
  output logic       enter_bor_o
);
  localparam int TW = $clog2(PWRT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(PWRT_CYC - 1);

  bor_state_t    state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          rst_q;
  logic          enter;

  always_comb begin
    state_d = state_q;
    tcnt_d  = '0;
    enter   = 1'b0;
    if (wdt) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_BOR: begin
          if (!low) state_d = pwrt_on ? ST_PWRT : ST_RUN;
        end
        ST_PWRT: begin
          if (low) begin
            state_d = ST_BOR;
            enter   = 1'b1;
          end else if (tcnt_q == T_LAST) begin
            state_d = ST_RUN;
          end else begin
            tcnt_d = tcnt_q + TW'(1);
          end
        end
        default: begin
          if (trip) begin
            state_d = ST_BOR;
            enter   = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      rst_q   <= (state_d != ST_RUN);
    end
  end

  assign state_o     = state_q;
  assign rst_o       = rst_q;
  assign enter_bor_o = enter;
endmodule

// File: rtl/bor_reset_seq.sv
module bor_reset_seq
  import bor_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 16,
  parameter int PWRT_CYC    = 65536
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       wdt_req_i,
  input  logic       brown_raw_i,
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  input  logic       pwrt_en_n_i,
  input  logic       flag_clr_i,
  output logic       rst_o,
  output logic       bor_flag_o
);
  logic       brown_s;
  logic       det_en;
  logic       brown_low;
  logic       trip;
  logic       enter_bor;
  bor_state_t state;
  logic       flag_q;

  // Supply assumed low at power-on so release waits for a seen-good supply
  bor_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (por_i),
    .d   (brown_raw_i),
    .q   (brown_s)
  );

  assign det_en    = det_enable(mode_i, sw_en_i, sleep_i);
  assign brown_low = brown_s & det_en;

  bor_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk  (clk),
    .rst  (por_i),
    .en   (det_en),
    .flag (brown_s),
    .trip (trip)
  );

  bor_seq_fsm #(.PWRT_CYC(PWRT_CYC)) u_fsm (
    .clk         (clk),
    .rst         (por_i),
    .low         (brown_low),
    .trip        (trip),
    .wdt         (wdt_req_i),
    .pwrt_on     (~pwrt_en_n_i),
    .state_o     (state),
    .rst_o       (rst_o),
    .enter_bor_o (enter_bor)
  );

  always_ff @(posedge clk) begin
    if (por_i)           flag_q <= 1'b0;
    else if (enter_bor)  flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign bor_flag_o = flag_q;
endmodule

// File: rtl/bor_reset_seq_chk.sv
module bor_reset_seq_chk
  import bor_pkg::*;
(
  input logic       clk,
  input logic       por_i,
  input logic       wdt_req_i,
  input logic       flag_clr_i,
  input logic       rst_o,
  input logic       bor_flag_o,
  input bor_state_t state,
  input logic       brown_low,
  input logic       trip,
  input logic       enter_bor
);
  p_por_asserts_r1: assert property (@(posedge clk)
    por_i |=> rst_o);

  p_hold_low_r6: assert property (@(posedge clk) disable iff (por_i)
    (state == ST_IDLE && brown_low && !wdt_req_i) |=> rst_o);

  p_dip_in_timer_r8: assert property (@(posedge clk) disable iff (por_i)
    (state == ST_PWRT && brown_low && !wdt_req_i) |=> (state == ST_BOR));

  p_wdt_reset_r9: assert property (@(posedge clk) disable iff (por_i)
    wdt_req_i |=> (rst_o && state == ST_IDLE));

  p_run_quiet_r5: assert property (@(posedge clk) disable iff (por_i)
    (state == ST_RUN && !trip && !wdt_req_i) |=> !rst_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (por_i)
    enter_bor |=> bor_flag_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (por_i)
    (flag_clr_i && !enter_bor) |=> !bor_flag_o);

  p_flag_with_reset_r10: assert property (@(posedge clk) disable iff (por_i)
    $rose(bor_flag_o) |-> rst_o);
endmodule

bind bor_reset_seq bor_reset_seq_chk u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .wdt_req_i  (wdt_req_i),
  .flag_clr_i (flag_clr_i),
  .rst_o      (rst_o),
  .bor_flag_o (bor_flag_o),
  .state      (state),
  .brown_low  (brown_low),
  .trip       (trip),
  .enter_bor  (enter_bor)
);

// File: tb/bor_reset_seq_bench.sv
module bor_reset_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int PWRT = 10;

  // {mode[1:0], sw_en, sleep, expect_reset}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_1_0_0,  // R2 off
    5'b01_0_0_0,  // R3 sw disabled
    5'b01_1_0_1,  // R3 sw enabled
    5'b10_0_1_0,  // R4 asleep
    5'b10_0_0_1,  // R4 awake, sw ignored
    5'b10_1_1_0,  // R4 sw cannot force on in sleep
    5'b11_0_1_1,  // R2 always on, sleeping
    5'b11_0_0_1   // R2 always on
  };

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       wdt_req_i = 1'b0;
  logic       brown_raw_i = 1'b0;
  logic [1:0] mode_i = 2'b11;
  logic       sw_en_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       pwrt_en_n_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       rst_o;
  logic       bor_flag_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bor_reset_seq #(.SYNC_STAGES(2), .FILT_CYC(FILT), .PWRT_CYC(PWRT)) u_bor_reset_seq (
    .clk         (clk),
    .por_i       (por_i),
    .wdt_req_i   (wdt_req_i),
    .brown_raw_i (brown_raw_i),
    .mode_i      (mode_i),
    .sw_en_i     (sw_en_i),
    .sleep_i     (sleep_i),
    .pwrt_en_n_i (pwrt_en_n_i),
    .flag_clr_i  (flag_clr_i),
    .rst_o       (rst_o),
    .bor_flag_o  (bor_flag_o)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_hold(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rst_o) n++;
      else break;
    end
  endtask

  task automatic watch(input int cyc, inout bit seen);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rst_o) seen = 1'b1;
    end
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
  endtask

  task automatic pulse_raw(input int len, output bit seen);
    seen = 1'b0;
    brown_raw_i = 1'b1;
    watch(len, seen);
    brown_raw_i = 1'b0;
    watch(12, seen);
  endtask

  initial begin
    int  n;
    bit  seen;
    int  first;

    repeat (3) @(negedge clk);
    chk(rst_o, 1, "R1 reset held during por");
    chk(bor_flag_o, 0, "R1 flag clear during por");

    // R7: power-up timer from por release
    por_i = 1'b0;
    count_hold(n);
    chk(n, PWRT + 2, "R7 por release with timer");

    // Table walk over modes, timer off
    pwrt_en_n_i = 1'b1;
    for (int v = 0; v < 8; v++) begin
      mode_i  = VEC[v][4:3];
      sw_en_i = VEC[v][2];
      sleep_i = VEC[v][1];
      @(negedge clk);
      pulse_raw(FILT + 6, seen);
      chk(seen, VEC[v][0], $sformatf("R2/R3/R4 vector %0d reset", v));
      chk(bor_flag_o, VEC[v][0], $sformatf("R10 vector %0d flag", v));
      chk(rst_o, 0, $sformatf("R7 vector %0d released", v));
      clear_flag();
    end
    mode_i = 2'b11; sw_en_i = 1'b0; sleep_i = 1'b0;

    // R5 glitch filter boundary
    pulse_raw(FILT, seen);
    chk(seen, 0, "R5 dip of FILT cycles filtered");
    pulse_raw(FILT + 1, seen);
    chk(seen, 1, "R5 dip of FILT+1 cycles resets");
    clear_flag();

    // R6 hold while low after por, then R7 release without timer
    brown_raw_i = 1'b1;
    por_i = 1'b1;
    repeat (2) @(negedge clk);
    por_i = 1'b0;
    seen = 1'b0;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_o) n++;
    end
    chk(n, 30, "R6 reset held while supply low");
    brown_raw_i = 1'b0;
    count_hold(n);
    chk(n, 2, "R7 release without timer");
    chk(bor_flag_o, 0, "R10 por does not set flag");

    // R8 dip during power-up timer restarts it
    pwrt_en_n_i = 1'b0;
    brown_raw_i = 1'b1;
    repeat (FILT + 6) @(negedge clk);
    brown_raw_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(rst_o, 1, "R8 timer running");
    brown_raw_i = 1'b1;
    repeat (2) @(negedge clk);
    brown_raw_i = 1'b0;
    count_hold(n);
    chk(n, PWRT + 2, "R8 timer restarted from zero");
    chk(bor_flag_o, 1, "R10 flag after brown-out");
    clear_flag();
    @(negedge clk);
    chk(bor_flag_o, 0, "R10 plain clear");

    // R9 watchdog request
    wdt_req_i = 1'b1;
    @(negedge clk);
    wdt_req_i = 1'b0;
    first = rst_o;
    count_hold(n);
    chk(first + n, PWRT + 1, "R9 watchdog reset length");
    chk(bor_flag_o, 0, "R9 watchdog leaves flag clear");

    // R10 set and clear in the same cycle
    pwrt_en_n_i = 1'b1;
    @(negedge clk);
    brown_raw_i = 1'b1;
    flag_clr_i  = 1'b1;
    repeat (FILT + 3) @(posedge clk);
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk(rst_o, 1, "R5 reset on qualified dip");
    @(negedge clk);
    chk(bor_flag_o, 1, "R10 set wins over clear");
    brown_raw_i = 1'b0;
    count_hold(n);
    chk(rst_o, 0, "R7 released after collision test");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule